// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects the completion events of a 16-channel DMA engine and turns them into one interrupt line. Each channel can raise three kinds of event: half transfer, package done and queue done. Each event is latched into a sticky pending bit. Each pending bit has a matching enable bit. The interrupt output is high whenever at least one pending bit is set and its enable bit is also set.

Software reaches the block through a plain 32-bit register port. The port has a write strobe, a byte address and write data, and read data that is combinational on the address. Each channel owns a 4-bit field, and eight channels share one 32-bit word, so there are two banks of enable words and two banks of pending words. A further read-only word shows the busy flags of all channels. Pending bits are cleared by writing ones. The normal handler reads a pending word and writes the same value back.

Top module: `dma_irq_agg`

## Requirements
- R1: After a synchronous reset, every enable and pending bit is 0 and `irq` is low.
- R2: Channel c uses bank c/8 and the nibble at bit 4*(c%8) of that bank's word. Inside the nibble, bit 0 is half transfer, bit 1 is package done and bit 2 is queue done. An event pulse sampled on a clock edge sets its pending bit from that edge on, whether or not the bit is enabled. The pending words are at byte addresses 0x10 (channels 0..7) and 0x14 (channels 8..15).
- R3: The enable words are at 0x00 (channels 0..7) and 0x04 (channels 8..15). A write takes effect at the clock edge, and a read returns the value written.
- R4: Writing a 1 to a bit of a pending word clears that bit. Writing a 0 leaves the bit unchanged. A set pending bit stays set until it is cleared this way.
- R5: If an event and a clear of the same pending bit fall on the same edge, the bit stays set.
- R6: `irq` is high exactly when some pending bit and its matching enable bit are both set. It is driven from the stored bits with no extra cycle of delay.
- R7: After 0 is written to both enable words, `irq` stays low, even while new events keep arriving.
- R8: A read of address 0x30 returns `chan_busy` in bits 15:0 and 0 in bits 31:16.
- R9: Bit 3 of every nibble in the enable and pending words always reads 0 and ignores writes. Any address other than 0x00, 0x04, 0x10, 0x14 and 0x30 reads 0. Writes to such addresses, and writes to 0x30, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_half | input | 16 | Per-channel half-transfer event pulses |
| evt_pkg | input | 16 | Per-channel package-done event pulses |
| evt_queue | input | 16 | Per-channel queue-done event pulses |
| chan_busy | input | 16 | Per-channel busy flags, shown at 0x30 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Aggregated interrupt request |

## Verification
The timing of each result is as follows:
- Read data and the busy word follow the address in the same cycle.
- Enable and pending bits change on the clock edge that samples the write or the event. Their new values are readable in the cycle after that edge.
- `irq` reflects the new stored state in that same following cycle.

The bench drives inputs just after the falling edge and compares read data and `irq` 1 ns later, against a behavioural per-channel model. That comparison shows the state left by the previous rising edge. The model is then advanced at the rising edge with the same inputs. Directed phases cover:
- the same-edge event-versus-clear case;
- the fully disabled case;
- reserved bits;
- unmapped addresses.

A pseudo-random phase then mixes events, writes and reads.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
package dma_irq_pkg;
    localparam int NUM_CH      = 16;
    localparam int FIELD_W     = 4;
    localparam int REG_W       = 32;
    localparam int ADDR_W      = 8;
    localparam int CH_PER_BANK = REG_W / FIELD_W;
    localparam int NUM_BANKS   = NUM_CH / CH_PER_BANK;

    localparam int EN_BASE     = 'h00;
    localparam int ST_BASE     = 'h10;
    localparam int GSTAT_ADDR  = 'h30;
    localparam int BANK_STRIDE = 4;

    typedef enum int {
        EV_HALF  = 0,
        EV_PKG   = 1,
        EV_QUEUE = 2
    } evt_e;

    localparam int EVT_N = 3;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } reg_req_t;

    function automatic logic [REG_W-1:0] live_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < CH_PER_BANK; k++)
            for (int e = 0; e < EVT_N; e++)
                m[k*FIELD_W+e] = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] pack_events(
        input logic [CH_PER_BANK-1:0] h,
        input logic [CH_PER_BANK-1:0] p,
        input logic [CH_PER_BANK-1:0] q
    );
        logic [REG_W-1:0] w;
        w = '0;
        for (int k = 0; k < CH_PER_BANK; k++) begin
            w[k*FIELD_W+int'(EV_HALF)]  = h[k];
            w[k*FIELD_W+int'(EV_PKG)]   = p[k];
            w[k*FIELD_W+int'(EV_QUEUE)] = q[k];
        end
        return w;
    endfunction
endpackage

// File: rtl/irq_bank.sv
`timescale 1ns/1ps
module irq_bank
    import dma_irq_pkg::*;
#(
    parameter int BANK_IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_req_t         req,
    input  logic [REG_W-1:0] ev_word,
    output logic [REG_W-1:0] en_q,
    output logic [REG_W-1:0] st_q
);
    localparam logic [REG_W-1:0]  MASK    = live_mask();
    localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(EN_BASE + BANK_IDX*BANK_STRIDE);
    localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(ST_BASE + BANK_IDX*BANK_STRIDE);

    logic             en_hit;
    logic             st_hit;
    logic [REG_W-1:0] clr_bits;

    always_comb begin
        en_hit   = req.wr && (req.addr == EN_ADDR);
        st_hit   = req.wr && (req.addr == ST_ADDR);
        clr_bits = st_hit ? req.data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (en_hit)
                en_q <= req.data & MASK;
            // a new event outranks a clear on the same edge
            st_q <= ((st_q & ~clr_bits) | ev_word) & MASK;
        end
    end
endmodule

// File: rtl/irq_readmux.sv
`timescale 1ns/1ps
module irq_readmux
    import dma_irq_pkg::*;
(
    input  logic [ADDR_W-1:0]                addr,
    input  logic [NUM_BANKS-1:0][REG_W-1:0]  en,
    input  logic [NUM_BANKS-1:0][REG_W-1:0]  st,
    input  logic [NUM_CH-1:0]                busy,
    output logic [REG_W-1:0]                 rdata
);
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(EN_BASE + b*BANK_STRIDE)) rdata = en[b];
            if (addr == ADDR_W'(ST_BASE + b*BANK_STRIDE)) rdata = st[b];
        end
        if (addr == ADDR_W'(GSTAT_ADDR)) rdata = REG_W'(busy);
    end
endmodule

// File: rtl/dma_irq_agg.sv
`timescale 1ns/1ps
module dma_irq_agg
    import dma_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] evt_half,
    input  logic [NUM_CH-1:0] evt_pkg,
    input  logic [NUM_CH-1:0] evt_queue,
    input  logic [NUM_CH-1:0] chan_busy,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    reg_req_t                        req;
    logic [NUM_BANKS-1:0][REG_W-1:0] bank_en;
    logic [NUM_BANKS-1:0][REG_W-1:0] bank_st;

    assign req = '{wr: reg_wr, addr: reg_addr, data: reg_wdata};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [REG_W-1:0] ev_word;
        assign ev_word = pack_events(evt_half [b*CH_PER_BANK +: CH_PER_BANK],
                                     evt_pkg  [b*CH_PER_BANK +: CH_PER_BANK],
                                     evt_queue[b*CH_PER_BANK +: CH_PER_BANK]);
        irq_bank #(.BANK_IDX(b)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .req    (req),
            .ev_word(ev_word),
            .en_q   (bank_en[b]),
            .st_q   (bank_st[b])
        );
    end

    irq_readmux u_rd (
        .addr (reg_addr),
        .en   (bank_en),
        .st   (bank_st),
        .busy (chan_busy),
        .rdata(reg_rdata)
    );

    always_comb begin
        irq = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++)
            irq = irq | (|(bank_en[b] & bank_st[b]));
    end
endmodule

// File: rtl/dma_irq_agg_chk.sv
`timescale 1ns/1ps
module dma_irq_agg_chk
    import dma_irq_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_CH-1:0]               evt_half,
    input logic [NUM_CH-1:0]               evt_pkg,
    input logic [NUM_CH-1:0]               evt_queue,
    input logic                            reg_wr,
    input logic [ADDR_W-1:0]               reg_addr,
    input logic [REG_W-1:0]                reg_wdata,
    input logic                            irq,
    input logic [NUM_BANKS-1:0][REG_W-1:0] bank_en,
    input logic [NUM_BANKS-1:0][REG_W-1:0] bank_st
);
    localparam logic [REG_W-1:0] RSV = ~live_mask();

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int B  = c / CH_PER_BANK;
        localparam int HB = (c % CH_PER_BANK) * FIELD_W;
        localparam logic [ADDR_W-1:0] SA = ADDR_W'(ST_BASE + B*BANK_STRIDE);

        p_half_latch_r2: assert property (@(posedge clk) disable iff (rst)
            evt_half[c] |=> bank_st[B][HB+int'(EV_HALF)]);
        p_pkg_latch_r2: assert property (@(posedge clk) disable iff (rst)
            evt_pkg[c] |=> bank_st[B][HB+int'(EV_PKG)]);
        p_queue_wins_r5: assert property (@(posedge clk) disable iff (rst)
            (evt_queue[c] && reg_wr && reg_addr == SA && reg_wdata[HB+int'(EV_QUEUE)])
            |=> bank_st[B][HB+int'(EV_QUEUE)]);
        p_half_clear_r4: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr == SA && reg_wdata[HB] && !evt_half[c])
            |=> !bank_st[B][HB]);
        p_half_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (bank_st[B][HB] && !(reg_wr && reg_addr == SA))
            |=> bank_st[B][HB]);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
        localparam logic [ADDR_W-1:0] EA = ADDR_W'(EN_BASE + b*BANK_STRIDE);
        p_en_write_r3: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr == EA) |=> bank_en[b] == ($past(reg_wdata) & ~RSV));
        p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
            ((bank_en[b] | bank_st[b]) & RSV) == '0);
    end

    p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (bank_en == '0) |-> !irq);
endmodule

bind dma_irq_agg dma_irq_agg_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_half (evt_half),
    .evt_pkg  (evt_pkg),
    .evt_queue(evt_queue),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .irq      (irq),
    .bank_en  (bank_en),
    .bank_st  (bank_st)
);

// File: tb/test_dma_irq_agg.sv
`timescale 1ns/1ps
module test_dma_irq_agg;
    import dma_irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       evt_half = '0, evt_pkg = '0, evt_queue = '0, chan_busy = '0;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    always #2.5 clk = ~clk;

    dma_irq_agg i_dma_irq_agg (
        .clk(clk), .rst(rst), .evt_half(evt_half), .evt_pkg(evt_pkg),
        .evt_queue(evt_queue), .chan_busy(chan_busy), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    bit    m_en [16][3];
    bit    m_st [16][3];
    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    done = 0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [15:0] busy);
        logic [31:0] w = '0;
        if (a == 8'h00 || a == 8'h04 || a == 8'h10 || a == 8'h14) begin
            int bank = (a % 16) / 4;
            for (int k = 0; k < 8; k++)
                for (int e = 0; e < 3; e++)
                    w[4*k+e] = (a < 8'h10) ? m_en[bank*8+k][e] : m_st[bank*8+k][e];
        end else if (a == 8'h30) begin
            w = {16'h0, busy};
        end
        return w;
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int c = 0; c < 16; c++)
            for (int e = 0; e < 3; e++)
                if (m_st[c][e] && m_en[c][e]) r = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic w, input logic [7:0] a, input logic [31:0] d,
                              input logic [15:0] h, input logic [15:0] p, input logic [15:0] q);
        for (int c = 0; c < 16; c++) begin
            for (int e = 0; e < 3; e++) begin
                int  b   = c / 8;
                int  pos = 4*(c % 8) + e;
                bit  ev  = (e == 0) ? h[c] : (e == 1) ? p[c] : q[c];
                bit  clr = w && (a == 8'(16 + 4*b)) && d[pos];
                m_st[c][e] = (m_st[c][e] && !clr) || ev;
                if (w && a == 8'(4*b)) m_en[c][e] = d[pos];
            end
        end
    endtask

    // one clock: drive after falling edge, compare, advance model at rising edge
    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic [15:0] h, input logic [15:0] p, input logic [15:0] q,
                       input logic [15:0] busy);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        evt_half = h; evt_pkg = p; evt_queue = q; chan_busy = busy;
        #1;
        chk(tag, "rdata", reg_rdata, exp_read(a, busy));
        chk(tag, "irq", {31'b0, irq}, {31'b0, exp_irq()});
        @(posedge clk);
        model_step(w, a, d, h, p, q);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(1'b0, a, 32'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        tag = "R1";
        rd(8'h00); rd(8'h04); rd(8'h10); rd(8'h14);

        // R3 enable write/readback; R9 reserved nibble bit dropped
        tag = "R3";
        cyc(1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd(8'h00);
        cyc(1, 8'h04, 32'h1234_5A6F, 0, 0, 0, 0);
        rd(8'h04);

        // R2 events latch with enables off for bank 1 lanes
        tag = "R2";
        cyc(1, 8'h04, 32'h0, 16'h0001, 16'h0200, 16'h8000, 0);
        rd(8'h10); rd(8'h14);
        cyc(0, 8'h10, 0, 16'h0000, 16'h0080, 16'h0010, 0);
        rd(8'h10);

        // R6 irq from enabled pending
        tag = "R6";
        cyc(1, 8'h04, 32'h2000_0000, 0, 0, 0, 0);
        rd(8'h14);

        // R4 write-one-to-clear; zeros leave bits alone
        tag = "R4";
        cyc(1, 8'h10, 32'h0000_0001, 0, 0, 0, 0);
        rd(8'h10);
        cyc(1, 8'h14, 32'h0000_0000, 0, 0, 0, 0);
        rd(8'h14);
        cyc(1, 8'h14, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd(8'h14);

        // R5 event and clear on the same edge
        tag = "R5";
        cyc(0, 8'h10, 0, 16'h0004, 0, 0, 0);
        cyc(1, 8'h10, 32'hFFFF_FFFF, 16'h0004, 0, 0, 0);
        rd(8'h10);

        // R7 both enables zero: no interrupt despite events
        tag = "R7";
        cyc(1, 8'h00, 32'h0, 0, 0, 0, 0);
        cyc(1, 8'h04, 32'h0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0);
        for (int i = 0; i < 4; i++) cyc(0, 8'h10, 0, 16'hA5A5, 16'h5A5A, 16'hFFFF, 0);
        rd(8'h14);

        // R8 busy word
        tag = "R8";
        cyc(0, 8'h30, 0, 0, 0, 0, 16'hBEEF);
        cyc(0, 8'h30, 0, 0, 0, 0, 16'h0001);
        cyc(0, 8'h30, 0, 0, 0, 0, 16'hFFFF);

        // R9 unmapped addresses and ignored writes
        tag = "R9";
        cyc(1, 8'h30, 32'hFFFF_FFFF, 0, 0, 0, 16'h00F0);
        cyc(1, 8'h08, 32'hFFFF_FFFF, 0, 0, 0, 0);
        cyc(1, 8'h20, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd(8'h08); rd(8'h18); rd(8'h00); rd(8'h04); rd(8'h10); rd(8'h14);
        cyc(1, 8'h10, 32'h8888_8888, 0, 0, 0, 0);
        rd(8'h10);

        // mixed traffic
        tag = "R6";
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r1, r2, r3;
            logic [7:0]  a;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5); r1 = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5); r2 = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5); r3 = seed;
            case (r1[2:0])
                3'd0: a = 8'h00;
                3'd1: a = 8'h04;
                3'd2, 3'd3: a = 8'h10;
                3'd4, 3'd5: a = 8'h14;
                3'd6: a = 8'h30;
                default: a = 8'h0C;
            endcase
            cyc(r1[7] & r1[8], a, r2, r3[15:0] & r2[31:16] & r1[31:16],
                r3[31:16] & r2[15:0] & r1[31:16], r3[15:0] & r3[31:16] & r2[31:16],
                r1[23:8]);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule